// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block is the priority core of a per-core interrupt controller. It holds a 256-bit request bitmap and a 256-bit in-service bitmap, one bit per vector. A fixed-mode vector that arrives on the arrival port sets its request bit. The block computes a processor priority from a programmable task-priority value and the highest vector now in service. It offers the highest pending vector to the core only when that vector's priority class beats the processor priority.

The core takes an offered vector by pulsing the acknowledge input. The vector then moves from pending to in service. An end-of-interrupt pulse retires the highest in-service vector, which may let a lower pending vector through. The highest in-service vector is kept in a cached register, so the block does not have to scan for it on each query. A byte-addressed register port exposes the task priority, the processor priority and both bitmaps. Each bitmap appears as eight 32-bit words placed 16 bytes apart.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, both bitmaps are clear, the task priority and processor priority are 0, `pending_any` is 0 and `ack_valid` is 0.
- R2: An arrival with vector v sets request bit v at the clock edge. From the next cycle `pending_any` is 1, and it stays 1 for as long as any request bit is set.
- R3: When `ack_valid` is 1, `ack_vector` is the highest-numbered vector whose request bit is set. When `ack_valid` is 0, `ack_vector` reads 0.
- R4: `ack_valid` is 1 only when the highest pending vector v meets `{v[7:4],4'h0} > ppr`. With no request bit set, it is 0.
- R5: `ppr` is the task priority when the task-priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that class with bits 3:0 zero. An empty in-service bitmap counts as class 0. `ppr` follows each acknowledge and each end-of-interrupt one cycle later.
- R6: `ack_take` while `ack_valid` is 1 and `eoi` is 0 clears the offered vector's request bit and sets its in-service bit. `ack_take` has no effect otherwise.
- R7: `eoi` clears the highest set in-service bit. When the in-service bitmap is empty, it has no effect.
- R8: If an arrival and an acknowledge name the same vector in one cycle, that vector ends up both pending and in service.
- R9: On the register port, 0x080 is the task priority (bits 7:0, read/write) and 0x0A0 is the processor priority (read-only). The in-service bitmap starts at 0x100 and the request bitmap at 0x200. Vector v sits at bit v%32 of the word at base + (v/32)*16. Reads are combinational. Every other address reads 0, and writes to any address other than 0x080 change nothing.
- R10: When `eoi` and `ack_take` are both high in one cycle, only the end-of-interrupt takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Vector arrival strobe |
| arr_vector | input | 8 | Arriving vector |
| ack_take | input | 1 | Core acknowledges the offered vector |
| ack_valid | output | 1 | An eligible vector is offered |
| ack_vector | output | 8 | Offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pending_any | output | 1 | Any request bit set |
| ppr | output | 8 | Current processor priority |

## Verification
All state changes at the clock edge where the strobe is sampled. `ack_valid`, `ack_vector`, `ppr`, `pending_any` and `reg_rdata` are combinational from that state, so each one shows its new value one cycle after the stimulus. The bench drives the inputs on the falling edge and compares every output 1 ns later, against a model state that was advanced at the previous rising edge. Register reads are combinational, so each read is checked in the same half-cycle in which its address is driven.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NVEC      = 256;
  localparam int VW        = $clog2(NVEC);
  localparam int WORD      = 32;
  localparam int NWORD     = NVEC / WORD;
  localparam int STRIDE    = 16;
  localparam int AW        = 12;
  localparam int DW        = 32;
  localparam int SPAN      = NWORD * STRIDE;
  localparam logic [AW-1:0] TPR_ADDR = 12'h080;
  localparam logic [AW-1:0] PPR_ADDR = 12'h0A0;
  localparam logic [AW-1:0] ISR_BASE = 12'h100;
  localparam logic [AW-1:0] IRR_BASE = 12'h200;

  // priority class of a vector: upper nibble, lower nibble zero
  function automatic logic [VW-1:0] vclass(input logic [VW-1:0] v);
    return {v[VW-1:4], 4'h0};
  endfunction

  // processor priority from task priority and top in-service vector
  function automatic logic [VW-1:0] calc_ppr(input logic [VW-1:0] tpr,
                                             input logic            isr_valid,
                                             input logic [VW-1:0] isr_top);
    logic [VW-1:0] cls;
    cls = isr_valid ? vclass(isr_top) : '0;
    return (vclass(tpr) >= cls) ? tpr : cls;
  endfunction
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int N = 256,
  parameter int W = 32
) (
  input  logic [N-1:0]         bits,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int NW = N / W;
  localparam int BW = $clog2(W);
  localparam int IW = $clog2(N);

  function automatic logic [BW-1:0] msb_of(input logic [W-1:0] w);
    logic [BW-1:0] p;
    p = '0;
    for (int b = 0; b < W; b++) if (w[b]) p = BW'(b);
    return p;
  endfunction

  logic [NW-1:0] nz;
  logic [BW-1:0] pos [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    assign nz[g]  = |bits[g*W +: W];
    assign pos[g] = msb_of(bits[g*W +: W]);
  end

  // highest non-zero word wins, then its most significant set bit
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int g = 0; g < NW; g++) begin
      if (nz[g]) begin
        found = 1'b1;
        idx   = IW'(g * W) + IW'(pos[g]);
      end
    end
  end
endmodule

// File: rtl/irq_prio_bitmaps.sv
module irq_prio_bitmaps
  import irq_prio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_valid,
  input  logic [VW-1:0]   set_vec,
  input  logic            ack_fire,
  input  logic [VW-1:0]   ack_vec,
  input  logic            eoi_req,
  output logic [NVEC-1:0] irr_q,
  output logic [NVEC-1:0] isr_q,
  output logic            top_valid,
  output logic [VW-1:0]   top_vec,
  output logic            eoi_fire,
  output logic            pend_q
);
  logic [NVEC-1:0] irr_n, isr_n, isr_after_eoi;
  logic            rescan_found;
  logic [VW-1:0]   rescan_idx;

  assign eoi_fire      = eoi_req && top_valid;
  assign isr_after_eoi = isr_q & ~({{(NVEC-1){1'b0}}, 1'b1} << top_vec);

  irq_prio_scan #(.N(NVEC), .W(WORD)) u_isr_rescan (
    .bits  (isr_after_eoi),
    .found (rescan_found),
    .idx   (rescan_idx)
  );

  always_comb begin
    irr_n = irr_q;
    if (ack_fire)  irr_n[ack_vec] = 1'b0;
    if (set_valid) irr_n[set_vec] = 1'b1;
    isr_n = isr_q;
    if (eoi_fire)      isr_n[top_vec] = 1'b0;
    else if (ack_fire) isr_n[ack_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q     <= '0;
      isr_q     <= '0;
      top_valid <= 1'b0;
      top_vec   <= '0;
      pend_q    <= 1'b0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      pend_q <= |irr_n;
      if (eoi_fire) begin
        top_valid <= rescan_found;
        top_vec   <= rescan_idx;
      end else if (ack_fire) begin
        top_valid <= 1'b1;
        top_vec   <= ack_vec;
      end
    end
  end

  // cached top in-service vector stays consistent with the bitmap (R5, R7)
  assert_cache_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> isr_q[top_vec]);
  assert_cache_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !top_valid |-> (isr_q == '0));
  assert_eoi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> !isr_q[$past(top_vec)]);
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [NVEC-1:0] irr,
  input  logic [NVEC-1:0] isr,
  input  logic [VW-1:0]   ppr,
  output logic [VW-1:0]   tpr_q,
  output logic [DW-1:0]   reg_rdata
);
  localparam int WB = $clog2(NWORD);

  function automatic logic in_bank(input logic [AW-1:0] a, input logic [AW-1:0] base);
    return (a >= base) && (a < base + AW'(SPAN)) && (a[3:0] == 4'h0);
  endfunction

  function automatic logic [WB-1:0] word_of(input logic [AW-1:0] a, input logic [AW-1:0] base);
    logic [AW-1:0] off;
    off = (a - base) >> $clog2(STRIDE);
    return off[WB-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                            tpr_q <= '0;
    else if (reg_wr && reg_addr == TPR_ADDR) tpr_q <= reg_wdata[VW-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == TPR_ADDR)               reg_rdata = DW'(tpr_q);
    else if (reg_addr == PPR_ADDR)          reg_rdata = DW'(ppr);
    else if (in_bank(reg_addr, ISR_BASE))   reg_rdata = isr[word_of(reg_addr, ISR_BASE)*WORD +: WORD];
    else if (in_bank(reg_addr, IRR_BASE))   reg_rdata = irr[word_of(reg_addr, IRR_BASE)*WORD +: WORD];
  end

  assert_tpr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != TPR_ADDR) |=> $stable(tpr_q));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arr_valid,
  input  logic [7:0]    arr_vector,
  input  logic          ack_take,
  output logic          ack_valid,
  output logic [7:0]    ack_vector,
  input  logic          eoi,
  input  logic          reg_wr,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          pending_any,
  output logic [7:0]    ppr
);
  logic [NVEC-1:0] irr_q, isr_q;
  logic            isr_top_valid, eoi_fire, req_found, ack_fire;
  logic [VW-1:0]   isr_top_vec, req_top, tpr_q;

  irq_prio_scan #(.N(NVEC), .W(WORD)) u_req_scan (
    .bits  (irr_q),
    .found (req_found),
    .idx   (req_top)
  );

  assign ppr        = calc_ppr(tpr_q, isr_top_valid, isr_top_vec);
  assign ack_valid  = req_found && (vclass(req_top) > ppr);
  assign ack_vector = ack_valid ? req_top : '0;
  assign ack_fire   = ack_take && ack_valid && !eoi;

  irq_prio_bitmaps u_maps (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (arr_valid),
    .set_vec   (arr_vector),
    .ack_fire  (ack_fire),
    .ack_vec   (ack_vector),
    .eoi_req   (eoi),
    .irr_q     (irr_q),
    .isr_q     (isr_q),
    .top_valid (isr_top_valid),
    .top_vec   (isr_top_vec),
    .eoi_fire  (eoi_fire),
    .pend_q    (pending_any)
  );

  irq_prio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irr       (irr_q),
    .isr       (isr_q),
    .ppr       (ppr),
    .tpr_q     (tpr_q),
    .reg_rdata (reg_rdata)
  );

  assert_arrival_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |=> (pending_any && irr_q[$past(arr_vector)]));
  assert_ack_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> irr_q[ack_vector]);
  assert_ack_above_isr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && isr_top_valid) |-> (ack_vector > isr_top_vec));
  assert_ppr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);
  assert_ack_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !(arr_valid && arr_vector == ack_vector))
      |=> (isr_q[$past(ack_vector)] && !irr_q[$past(ack_vector)]));
  assert_same_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && arr_valid && arr_vector == ack_vector)
      |=> (irr_q[$past(arr_vector)] && isr_q[$past(arr_vector)]));
  assert_eoi_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && ack_take) |=> ($countones(isr_q) <= $countones($past(isr_q))));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arr_valid = 1'b0, ack_take = 1'b0, eoi = 1'b0, reg_wr = 1'b0;
  logic [7:0]  arr_vector = '0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        ack_valid, pending_any;
  logic [7:0]  ack_vector, ppr;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  logic [255:0] m_irr = '0, m_isr = '0;
  logic [7:0]   m_tpr = '0;

  always #10 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_vector(arr_vector),
    .ack_take(ack_take), .ack_valid(ack_valid), .ack_vector(ack_vector), .eoi(eoi),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pending_any(pending_any), .ppr(ppr)
  );

  function automatic int top_of(input logic [255:0] b);
    for (int i = 255; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_ppr();
    int t;
    int cls;
    t   = top_of(m_isr);
    cls = (t < 0) ? 0 : (t / 16) * 16;
    return ((m_tpr / 16) * 16 >= cls) ? m_tpr : 8'(cls);
  endfunction

  function automatic logic exp_valid();
    int p;
    p = top_of(m_irr);
    return (p >= 0) && ((p / 16) * 16 > int'(exp_ppr()));
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int ia;
    ia = int'(a);
    if (ia == 'h080) return {24'h0, m_tpr};
    if (ia == 'h0A0) return {24'h0, exp_ppr()};
    if (ia >= 'h100 && ia < 'h180 && ia % 16 == 0) return m_isr[((ia - 'h100) / 16) * 32 +: 32];
    if (ia >= 'h200 && ia < 'h280 && ia % 16 == 0) return m_irr[((ia - 'h200) / 16) * 32 +: 32];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // drive one cycle at the falling edge, check outputs, advance the model
  task automatic step(input bit av, input logic [7:0] avec, input bit ak, input bit eo,
                      input bit wr, input logic [11:0] addr, input logic [31:0] wd);
    logic ev;
    int   p, t;
    arr_valid = av; arr_vector = avec; ack_take = ak; eoi = eo;
    reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    #1;
    ev = exp_valid();
    p  = top_of(m_irr);
    chk("R4 ack_valid", 32'(ack_valid), 32'(ev));
    chk("R3 ack_vector", 32'(ack_vector), ev ? 32'(p) : 32'h0);
    chk("R5 ppr", 32'(ppr), 32'(exp_ppr()));
    chk("R2 pending_any", 32'(pending_any), 32'(m_irr != '0));
    chk("R9 reg_rdata", reg_rdata, exp_rd(addr));
    t = top_of(m_isr);
    if (ak && ev && !eo) m_irr[p] = 1'b0;      // R6
    if (av) m_irr[avec] = 1'b1;                 // R2, R8
    if (eo && t >= 0) m_isr[t] = 1'b0;          // R7, R10
    else if (ak && ev && !eo) m_isr[p] = 1'b1;  // R6
    if (wr && addr == 12'h080) m_tpr = wd[7:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk("R1 ack_valid", 32'(ack_valid), 32'h0);
    chk("R1 pending_any", 32'(pending_any), 32'h0);
    chk("R1 ppr", 32'(ppr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 8; w++) step(0, 0, 0, 0, 0, 12'(12'h100 + w * 16), 0);
    for (int w = 0; w < 8; w++) step(0, 0, 0, 0, 0, 12'(12'h200 + w * 16), 0);
    // R2/R9: arrival visible at word 2 bit 5 of the request bank
    step(1, 8'h45, 0, 0, 0, 12'h220, 0);
    step(0, 0, 0, 0, 0, 12'h220, 0);
    // R8: arrival and acknowledge of the same vector
    step(1, 8'h45, 1, 0, 0, 12'h220, 0);
    step(0, 0, 0, 0, 0, 12'h120, 0);
    step(0, 0, 0, 0, 0, 12'h220, 0);
    // R4/R5: in-service 0x45 masks the pending 0x45, then a higher vector passes
    step(1, 8'h9a, 0, 0, 0, 12'h0A0, 0);
    step(0, 0, 1, 0, 0, 12'h0A0, 0);
    // R10: eoi and acknowledge together
    step(0, 0, 1, 1, 0, 12'h120, 0);
    step(0, 0, 1, 1, 0, 12'h120, 0);
    // R7: eoi with empty in-service bitmap
    step(0, 0, 0, 1, 0, 12'h120, 0);
    // R5/R9: task priority masking, write to a read-only address ignored
    step(0, 0, 0, 0, 1, 12'h080, 32'h50);
    step(0, 0, 1, 0, 1, 12'h0A0, 32'hff);
    step(0, 0, 0, 0, 1, 12'h200, 32'hffff_ffff);
    step(0, 0, 1, 0, 1, 12'h080, 32'h3f);
    step(0, 0, 1, 0, 0, 12'h0A0, 0);
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      int sel;
      sel = int'($urandom % 5);
      case (sel)
        0: a = 12'h080;
        1: a = 12'h0A0;
        2: a = 12'(12'h100 + ($urandom % 8) * 16);
        3: a = 12'(12'h200 + ($urandom % 8) * 16);
        default: a = 12'($urandom);
      endcase
      step(($urandom % 2) == 0, 8'($urandom), ($urandom % 5) < 2, ($urandom % 7) == 0,
           ($urandom % 16) == 0, a, ($urandom % 3 == 0) ? 32'($urandom % 'h70) : 32'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule